// File: doc/BRIEF.md
# Emulated Punched-Card Reader/Punch Adapter

This block lets a processor's I/O channel drive a punched-card reader/punch that exists only as buffer memory. A host-side agent writes a card image, one 12-bit column at a time, into a pre-read buffer and then marks the hopper as loaded. Once the processor has started a feed, the host drains the finished card from the pre-punch buffer. The adapter then copies the waiting card from the pre-read buffer into the pre-punch buffer, where the processor reads it and can punch it.

The processor issues single-cycle commands: feed, column read, column punch, stacker select and sense-with-reset. Reads and punches move through the 80 columns one command at a time. The end of a feed, the last column read and the last column punched each raise one interrupt pulse and set a sticky operation-complete bit in the status word. If the hopper is empty when a feed is asked for, the device either goes not-ready until more cards arrive, or, when the last-card option is set, it flags the card just fed as the last one.

Top module: `card_adapter`

## Requirements
- R1: A card has 80 columns of 12 bits. A read command (cmd_op=2) accepted at clock edge E presents the pre-punch column at the current column counter on col_data, with its address on col_idx and col_strobe high, from edge E+1 for exactly one cycle.
- R2: Each accepted read advances the column counter by exactly one. After column 79 has been read, further reads produce no strobe.
- R3: col_data and col_idx change only in a cycle in which col_strobe is high.
- R4: A feed command (cmd_op=1) with a loaded hopper raises fetch_req. While fetch_req is high, host_rd_col addresses the pre-punch buffer, and host_rd_data returns the old contents one cycle later. A host_fetch_done pulse then starts a copy of the pre-read buffer into the pre-punch buffer, and the column counter restarts at 0.
- R5: A finished feed, the read of column 79 and the punch of column 79 each produce exactly one single-cycle irq pulse.
- R6: A feed with an empty hopper while host_last_opt=0 sets not-ready (dsw bit 0), starts no fetch and raises no irq. Not-ready stays set until host_load_done.
- R7: With host_last_opt=1, a feed that leaves the hopper empty sets the last-card bit (dsw bit 3). A later feed on the empty hopper leaves the device ready. host_load_done clears the bit.
- R8: A punch command (cmd_op=3) writes cmd_data into the pre-punch buffer at the current column and advances the counter. The host sees the punched image at the next fetch.
- R9: A stacker-select command (cmd_op=4) records cmd_data bit 0 in dsw bit 4 for the current card. The bit clears when the next feed completes.
- R10: The status word has not-ready at bit 0, busy at bit 1, operation-complete at bit 2, last-card at bit 3 and stacker at bit 4, and all other bits are 0. Operation-complete is set together with irq and cleared by sense-with-reset (cmd_op=5).
- R11: A read while not-ready produces no strobe and leaves the column counter unchanged.
- R12: After reset the device is not-ready with dsw=16'h0001, and irq, col_strobe and fetch_req are low.
- R13: Commands arriving while busy (dsw bit 1 set) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe into the pre-read buffer |
| host_wr_col | input | 7 | Column address for the host write |
| host_wr_data | input | 12 | Column image for the host write |
| host_load_done | input | 1 | Pulse: the pre-read card is complete and the hopper is loaded |
| host_last_opt | input | 1 | Last-card option |
| fetch_req | output | 1 | Pre-punch buffer is open for the host to fetch |
| host_rd_col | input | 7 | Pre-punch column address used during a fetch |
| host_rd_data | output | 12 | Pre-punch column, one cycle after the address |
| host_fetch_done | input | 1 | Pulse: the host has finished fetching |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | Command: 1 feed, 2 read, 3 punch, 4 stacker, 5 sense-reset |
| cmd_data | input | 12 | Punch image, or stacker choice in bit 0 |
| col_strobe | output | 1 | A new read column is presented |
| col_idx | output | 7 | Address of the presented column |
| col_data | output | 12 | Image of the presented column |
| irq | output | 1 | Operation-complete pulse |
| dsw | output | 16 | Device status word |

## Verification
A table of card images is each fed in and read back in full. The images are all zeros, all ones, a seed XORed with the column address, a walking one and an arithmetic ramp. A stuck row bit, a swapped column order or an off-by-one in the copy pipeline each makes at least one of these images fail. Every fetch is checked against the previous card, which separates a copy that went wrong from a fetch that went wrong. Punching all 80 columns and then fetching shows that punched data reaches the host, and that the interrupt comes only on the final column. Directed sequences cover the hopper running empty with and without the last-card option, reads while not-ready that must keep the counter where it was, commands sent while busy, and reads beyond column 79.

// File: rtl/card_pkg.sv
`timescale 1ns/1ps
package card_pkg;
  localparam int NCOLS = 80;
  localparam int NROWS = 12;
  localparam int DSW_W = 16;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_FEED  = 3'd1,
    OP_READ  = 3'd2,
    OP_PUNCH = 3'd3,
    OP_STACK = 3'd4,
    OP_SENSE = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RDW, S_FETCH, S_COPY, S_CLAST
  } st_e;

  localparam int B_NRDY = 0;
  localparam int B_BUSY = 1;
  localparam int B_OPC  = 2;
  localparam int B_LAST = 3;
  localparam int B_STK  = 4;
endpackage

// File: rtl/card_ram.sv
`timescale 1ns/1ps
module card_ram #(
  parameter int DEPTH = 80,
  parameter int WIDTH = 12,
  parameter int AW    = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/card_ctrl.sv
`timescale 1ns/1ps
module card_ctrl
  import card_pkg::*;
#(
  parameter int COLS = NCOLS,
  parameter int ROWS = NROWS,
  parameter int CW   = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [ROWS-1:0]  cmd_data,
  input  logic             last_opt,
  input  logic             load_done,
  input  logic             fetch_done,
  input  logic [CW-1:0]    host_rd_col,
  output logic [CW-1:0]    pr_raddr,
  input  logic [ROWS-1:0]  pr_rdata,
  output logic [CW-1:0]    pp_raddr,
  input  logic [ROWS-1:0]  pp_rdata,
  output logic             pp_we,
  output logic [CW-1:0]    pp_waddr,
  output logic [ROWS-1:0]  pp_wdata,
  output logic             fetch_req,
  output logic             col_strobe,
  output logic [CW-1:0]    col_idx,
  output logic [ROWS-1:0]  col_data,
  output logic             irq,
  output logic [DSW_W-1:0] dsw
);
  localparam logic [CW-1:0] LASTCOL = CW'(COLS - 1);
  localparam logic [CW-1:0] ENDCOL  = CW'(COLS);

  st_e             state;
  logic [CW-1:0]   col_cnt;
  logic [CW-1:0]   cp_idx;
  logic [CW-1:0]   cp_widx;
  logic            cp_wv;
  logic            nrdy, opc, lastc, stk, hop;
  logic            col_left;
  logic            punch_fire;

  assign col_left   = (col_cnt < ENDCOL);
  assign punch_fire = (state == S_IDLE) && cmd_valid && (cmd_op == OP_PUNCH)
                      && !nrdy && col_left;

  // buffer ports: copy write and punch write never overlap in time
  always_comb begin
    pr_raddr = cp_idx;
    pp_we    = cp_wv || punch_fire;
    pp_waddr = cp_wv ? cp_widx : col_cnt;
    pp_wdata = cp_wv ? pr_rdata : cmd_data;
    if (state == S_FETCH) pp_raddr = host_rd_col;
    else                  pp_raddr = col_left ? col_cnt : '0;
  end

  assign fetch_req = (state == S_FETCH);

  always_comb begin
    dsw         = '0;
    dsw[B_NRDY] = nrdy;
    dsw[B_BUSY] = (state != S_IDLE);
    dsw[B_OPC]  = opc;
    dsw[B_LAST] = lastc;
    dsw[B_STK]  = stk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      col_cnt    <= ENDCOL;
      cp_idx     <= '0;
      cp_widx    <= '0;
      cp_wv      <= 1'b0;
      nrdy       <= 1'b1;
      opc        <= 1'b0;
      lastc      <= 1'b0;
      stk        <= 1'b0;
      hop        <= 1'b0;
      irq        <= 1'b0;
      col_strobe <= 1'b0;
      col_idx    <= '0;
      col_data   <= '0;
    end else begin
      irq        <= 1'b0;
      col_strobe <= 1'b0;
      cp_wv      <= 1'b0;
      if (load_done) begin
        hop   <= 1'b1;
        nrdy  <= 1'b0;
        lastc <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            case (op_e'(cmd_op))
              OP_FEED: begin
                if (hop) state <= S_FETCH;
                else if (!last_opt && !load_done) nrdy <= 1'b1;
              end
              OP_READ: begin
                if (!nrdy && col_left) state <= S_RDW;
              end
              OP_PUNCH: begin
                if (punch_fire) begin
                  col_cnt <= col_cnt + 1'b1;
                  if (col_cnt == LASTCOL) begin
                    irq <= 1'b1;
                    opc <= 1'b1;
                  end
                end
              end
              OP_STACK: stk <= cmd_data[0];
              OP_SENSE: opc <= 1'b0;
              default: ;
            endcase
          end
        end
        S_RDW: begin
          // index and data leave the register together, one edge after the RAM read
          col_data   <= pp_rdata;
          col_idx    <= col_cnt;
          col_strobe <= 1'b1;
          col_cnt    <= col_cnt + 1'b1;
          if (col_cnt == LASTCOL) begin
            irq <= 1'b1;
            opc <= 1'b1;
          end
          state <= S_IDLE;
        end
        S_FETCH: begin
          if (fetch_done) begin
            state  <= S_COPY;
            cp_idx <= '0;
          end
        end
        S_COPY: begin
          cp_wv   <= 1'b1;
          cp_widx <= cp_idx;
          cp_idx  <= cp_idx + 1'b1;
          if (cp_idx == LASTCOL) state <= S_CLAST;
        end
        S_CLAST: begin
          state   <= S_IDLE;
          col_cnt <= '0;
          hop     <= load_done;
          lastc   <= last_opt && !load_done;
          stk     <= 1'b0;
          irq     <= 1'b1;
          opc     <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: the column counter only steps by one or restarts at zero
  p_one_step_r2: assert property (@(posedge clk) disable iff (rst)
    (col_cnt != $past(col_cnt)) |-> (col_cnt == $past(col_cnt) + 1'b1 || col_cnt == '0));

  p_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !col_strobe |-> ($stable(col_data) && $stable(col_idx)));

  p_copy_after_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_COPY && $past(state) != S_COPY) |-> ($past(state) == S_FETCH && $past(fetch_done)));

  p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_nrdy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (nrdy && !load_done) |=> nrdy);

  p_nrdy_read_r11: assert property (@(posedge clk) disable iff (rst)
    (nrdy && state == S_IDLE && cmd_valid && cmd_op == OP_READ) |=> (state == S_IDLE && $stable(col_cnt)));
endmodule

// File: rtl/card_adapter.sv
`timescale 1ns/1ps
module card_adapter
  import card_pkg::*;
#(
  parameter int COLS = NCOLS,
  parameter int ROWS = NROWS,
  parameter int CW   = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr_en,
  input  logic [CW-1:0]    host_wr_col,
  input  logic [ROWS-1:0]  host_wr_data,
  input  logic             host_load_done,
  input  logic             host_last_opt,
  output logic             fetch_req,
  input  logic [CW-1:0]    host_rd_col,
  output logic [ROWS-1:0]  host_rd_data,
  input  logic             host_fetch_done,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [ROWS-1:0]  cmd_data,
  output logic             col_strobe,
  output logic [CW-1:0]    col_idx,
  output logic [ROWS-1:0]  col_data,
  output logic             irq,
  output logic [DSW_W-1:0] dsw
);
  logic [CW-1:0]   pr_raddr, pp_raddr, pp_waddr;
  logic [ROWS-1:0] pr_rdata, pp_rdata, pp_wdata;
  logic            pp_we;

  card_ram #(.DEPTH(COLS), .WIDTH(ROWS), .AW(CW)) u_preread (
    .clk(clk), .we(host_wr_en), .waddr(host_wr_col), .wdata(host_wr_data),
    .raddr(pr_raddr), .rdata(pr_rdata));

  card_ram #(.DEPTH(COLS), .WIDTH(ROWS), .AW(CW)) u_prepunch (
    .clk(clk), .we(pp_we), .waddr(pp_waddr), .wdata(pp_wdata),
    .raddr(pp_raddr), .rdata(pp_rdata));

  assign host_rd_data = pp_rdata;

  card_ctrl #(.COLS(COLS), .ROWS(ROWS), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .last_opt(host_last_opt), .load_done(host_load_done),
    .fetch_done(host_fetch_done), .host_rd_col(host_rd_col),
    .pr_raddr(pr_raddr), .pr_rdata(pr_rdata),
    .pp_raddr(pp_raddr), .pp_rdata(pp_rdata),
    .pp_we(pp_we), .pp_waddr(pp_waddr), .pp_wdata(pp_wdata),
    .fetch_req(fetch_req), .col_strobe(col_strobe), .col_idx(col_idx),
    .col_data(col_data), .irq(irq), .dsw(dsw));
endmodule

// File: tb/card_adapter_tb.sv
`timescale 1ns/1ps
module card_adapter_tb;
  localparam int C = 80;

  logic clk = 0, rst = 1;
  logic host_wr_en = 0, host_load_done = 0, host_last_opt = 0, host_fetch_done = 0;
  logic [6:0] host_wr_col = 0, host_rd_col = 0;
  logic [11:0] host_wr_data = 0, cmd_data = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic fetch_req, col_strobe, irq;
  logic [6:0] col_idx;
  logic [11:0] col_data, host_rd_data;
  logic [15:0] dsw;

  int checks = 0, bad = 0;
  bit finished = 0;
  logic [11:0] exp_pr [C];
  logic [11:0] exp_pp [C];

  // mode in [13:12], seed in [11:0]
  localparam logic [13:0] VEC [5] = '{
    {2'd0, 12'h000}, {2'd0, 12'hFFF}, {2'd1, 12'h5A5}, {2'd2, 12'h000}, {2'd3, 12'h123}};

  always #2.5 clk = ~clk;

  card_adapter u_dut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_col(host_wr_col),
    .host_wr_data(host_wr_data), .host_load_done(host_load_done),
    .host_last_opt(host_last_opt), .fetch_req(fetch_req), .host_rd_col(host_rd_col),
    .host_rd_data(host_rd_data), .host_fetch_done(host_fetch_done),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .col_strobe(col_strobe), .col_idx(col_idx), .col_data(col_data),
    .irq(irq), .dsw(dsw));

  function automatic logic [11:0] pat(input logic [1:0] mode, input logic [11:0] seed, input int c);
    case (mode)
      2'd0: return seed;
      2'd1: return seed ^ 12'(c);
      2'd2: return 12'(1 << (c % 12));
      default: return 12'(seed + c * 37);
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [11:0] d);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_data = d;
    @(negedge clk); cmd_valid = 0; cmd_op = 0; cmd_data = 0;
  endtask

  task automatic load_card(input logic [1:0] mode, input logic [11:0] seed);
    for (int c = 0; c < C; c++) begin
      @(negedge clk); host_wr_en = 1; host_wr_col = 7'(c);
      host_wr_data = pat(mode, seed, c); exp_pr[c] = host_wr_data;
    end
    @(negedge clk); host_wr_en = 0; host_load_done = 1;
    @(negedge clk); host_load_done = 0;
  endtask

  task automatic feed_start();
    do_cmd(3'd1, 0);
    chk("R4 fetch_req", fetch_req, 1);
  endtask

  task automatic feed_finish(input bit check_fetch);
    int n;
    if (check_fetch)
      for (int c = 0; c < C; c++) begin
        host_rd_col = 7'(c);
        @(negedge clk);
        chk("R4 fetch old card", host_rd_data, exp_pp[c]);
      end
    host_fetch_done = 1;
    @(negedge clk); host_fetch_done = 0;
    n = 0;
    repeat (100) begin @(negedge clk); if (irq) n++; end
    chk("R5 one irq per feed", n, 1);
    chk("R4 not busy after feed", dsw[1], 0);
    for (int c = 0; c < C; c++) exp_pp[c] = exp_pr[c];
  endtask

  task automatic read_col(input int idx, input logic [11:0] d, input bit last);
    do_cmd(3'd2, 0);
    @(negedge clk);
    chk("R1 strobe", col_strobe, 1);
    chk("R2 col_idx", col_idx, idx);
    chk("R1 col_data", col_data, d);
    chk("R5 irq on last column", irq, last);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 dsw", dsw, 16'h0001);
    chk("R12 irq", irq, 0);
    chk("R12 strobe", col_strobe, 0);
    chk("R12 fetch_req", fetch_req, 0);
    do_cmd(3'd2, 0); @(negedge clk);
    chk("R11 read ignored before cards", col_strobe, 0);

    // table of card images
    for (int v = 0; v < 5; v++) begin
      load_card(VEC[v][13:12], VEC[v][11:0]);
      chk("R6 ready after load", dsw[0], 0);
      feed_start();
      feed_finish(v > 0);
      for (int c = 0; c < C; c++) read_col(c, exp_pp[c], c == C - 1);
    end

    do_cmd(3'd2, 0); @(negedge clk);
    chk("R2 read past column 79", col_strobe, 0);
    chk("R10 opc set", dsw[2], 1);
    do_cmd(3'd5, 0);
    chk("R10 opc cleared by sense", dsw[2], 0);

    // R13: command while busy
    load_card(2'd3, 12'h0F0);
    feed_start();
    do_cmd(3'd2, 0); @(negedge clk);
    chk("R13 read ignored while busy", col_strobe, 0);
    chk("R13 busy", dsw[1], 1);
    feed_finish(1);

    // R9 stacker and R8 punch
    do_cmd(3'd4, 12'h001);
    chk("R9 stacker recorded", dsw[4], 1);
    for (int c = 0; c < C; c++) begin
      do_cmd(3'd3, 12'(c * 3 + 7));
      exp_pp[c] = 12'(c * 3 + 7);
      chk("R8 punch irq only on last", irq, c == C - 1);
    end
    load_card(2'd1, 12'h3C3);
    feed_start();
    feed_finish(1);
    chk("R9 stacker cleared by feed", dsw[4], 0);

    // R6 / R11: empty hopper without last-card option
    read_col(0, exp_pp[0], 0);
    read_col(1, exp_pp[1], 0);
    read_col(2, exp_pp[2], 0);
    do_cmd(3'd1, 0);
    chk("R6 not-ready", dsw[0], 1);
    chk("R6 no fetch", fetch_req, 0);
    chk("R6 no irq", irq, 0);
    do_cmd(3'd2, 0); @(negedge clk);
    chk("R11 read ignored while not-ready", col_strobe, 0);
    repeat (5) @(negedge clk);
    chk("R6 not-ready held", dsw[0], 1);
    load_card(2'd0, 12'hABC);
    chk("R6 ready after load", dsw[0], 0);
    read_col(3, exp_pp[3], 0);

    // R7 last-card option
    host_last_opt = 1;
    feed_start();
    feed_finish(1);
    chk("R7 last-card bit", dsw[3], 1);
    do_cmd(3'd1, 0);
    chk("R7 stays ready", dsw[0], 0);
    chk("R7 no fetch on empty hopper", fetch_req, 0);
    chk("R7 last-card kept", dsw[3], 1);
    load_card(2'd0, 12'h111);
    chk("R7 last-card cleared by load", dsw[3], 0);
    chk("R10 unused bits zero", dsw[15:5], 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule